// File: doc/BRIEF.md
# Receiver Wake-Up and Gain-Recovery Controller

This block is the digital control logic of an on-off-keyed receiver that is switched on and off to save power. It runs from the reference oscillator clock. It takes two asynchronous inputs: a standby request and a raw carrier-detect level. It produces three outputs. The first is an active-low wake flag that tells downstream decoders a steady carrier is present. The second is an enable for the charge and discharge sources of the automatic gain control. The third is a boost strobe that raises those sources to 45 times their normal strength for a fixed number of reference cycles after the receiver leaves standby.

A prescaler divides the reference clock into slow ticks. A qualification counter counts those ticks while the carrier stays high. The wake flag falls once the counter has seen `QUAL_TICKS` ticks without a break. It rises again as soon as the carrier goes away, so each wake pulse lasts as long as the carrier persists beyond the qualification time.

Standby overrides everything. While in standby, the prescaler and the counter are held clear, the flag is held high, and both gain sources are off, which leaves the hold capacitor floating. Leaving standby turns the sources on and opens the boost window. Both inputs pass through two-flop synchronizers. After reset the block starts in standby.

Top module: `rxwk_ctrl`

## Requirements
Edge numbering: E0 is the first rising clock edge that samples `shut_req` low, and Ej is the j-th rising edge after E0. "After Ej" means the output value held between Ej and Ej+1.

- R1: While `rst_n` is low, and afterwards until standby is left, `wake_n` = 1, `agc_en` = 0 and `agc_boost` = 0.
- R2: With `carrier_raw` held high since before E0, `wake_n` is 1 up to and including after E(QUAL_TICKS*TICK_DIV) and is 0 after E(QUAL_TICKS*TICK_DIV+1). Ticks fall every TICK_DIV cycles, and their phase is restarted by each release from standby.
- R3: Any carrier gap that reaches the synchronizer output restarts qualification. Let the rising `carrier_raw` be first sampled at edge E(g-1). Then `wake_n` falls after edge E((k+QUAL_TICKS-1)*TICK_DIV+1), where k = max(1, ceil(g/TICK_DIV)). Before that edge it stays 1.
- R4: When `carrier_raw` falls and is first sampled low at edge F0, `wake_n` is still 0 after F1 and is 1 after F2.
- R5: While the block is in standby, `wake_n` stays 1 and `agc_boost` stays 0 whatever `carrier_raw` does.
- R6: `agc_en` becomes 1 after E2. It returns to 0 two edges after the edge that first samples `shut_req` high.
- R7: `agc_boost` is 1 after E2 through after E(BOOST_CYCLES+1), and 0 after E(BOOST_CYCLES+2). That is exactly BOOST_CYCLES cycles.
- R8: If `shut_req` rises during the boost window, `agc_boost` drops in the same cycle as `agc_en`. The next release opens a full BOOST_CYCLES window.
- R9: If `shut_req` is first sampled high at edge E(W-2), where W is the edge at which the wake flag would otherwise fall, then `wake_n` never goes low. Standby wins over the final tick.
- R10: When the wake edge W lies inside the boost window, `wake_n` falls at W while `agc_boost` stays 1. The two functions do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shut_req | input | 1 | Asynchronous standby request, high = standby |
| carrier_raw | input | 1 | Asynchronous raw carrier-detect level |
| wake_n | output | 1 | Active-low wake flag |
| agc_en | output | 1 | Enable for the gain-control charge and discharge sources |
| agc_boost | output | 1 | Strobe for 45x source strength after leaving standby |

## Verification
Two kinds of same-cycle events are provoked on purpose.

The first is the wake flag falling while the boost window is still open. The bench parameters put the qualification time well inside the window. Every cycle is then compared against independently computed edges for `wake_n`, `agc_boost` and `agc_en`.

The second is a standby request that reaches the logic in exactly the cycle the final qualifying tick would be counted. This case is judged by `wake_n` never falling and by the boost and enable outputs dropping together.

Random carrier gaps and random standby instants are also placed around tick boundaries. Each one is checked against the restart formula of R3.

// File: rtl/rxwk_pkg.sv
package rxwk_pkg;

  localparam int unsigned DEF_TICK_DIV     = 256;
  localparam int unsigned DEF_QUAL_TICKS   = 128;
  localparam int unsigned DEF_BOOST_CYCLES = 65536;

  // counter width able to hold values 0 .. n-1 (at least one bit)
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/rxwk_sync.sv
module rxwk_sync #(
  parameter int unsigned           WIDTH   = 1,
  parameter logic [WIDTH-1:0]      RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign q_sync = sync_q;

endmodule

// File: rtl/rxwk_prescale.sv
module rxwk_prescale
  import rxwk_pkg::*;
#(
  parameter int unsigned DIV = DEF_TICK_DIV
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);

  localparam int unsigned CW   = cnt_w(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)             cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = run_i && (cnt_q == LAST);

  generate
    if (DIV > 1) begin : g_spacing
      // R2: consecutive ticks are never adjacent when dividing
      a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate

  // R5: a stopped prescaler restarts from zero phase
  a_r5_idle_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !tick_o || (DIV == 1));

endmodule

// File: rtl/rxwk_qual.sv
module rxwk_qual
  import rxwk_pkg::*;
#(
  parameter int unsigned QUAL = DEF_QUAL_TICKS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  input  logic carrier_i,
  input  logic tick_i,
  output logic active_o
);

  localparam int unsigned CW   = cnt_w(QUAL + 1);
  localparam logic [CW-1:0] FULL = CW'(QUAL);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;

  always_comb begin
    cnt_d = cnt_q;
    if (hold_i || !carrier_i)          cnt_d = '0;
    else if (tick_i && cnt_q != FULL)  cnt_d = cnt_q + CW'(1);
    act_d = (cnt_d == FULL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign active_o = act_q;

  // R4: carrier loss clears the flag on the next edge
  a_r4_loss_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !carrier_i |=> !active_o);

  // R5: standby holds the flag and counter clear
  a_r5_hold_clear: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (!active_o && cnt_q == '0));

  // R3: the flag only rises on a counted tick
  a_r3_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> $past(tick_i && carrier_i && !hold_i));

  // R2: once raised the flag persists while carrier stays and no standby
  a_r2_flag_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && carrier_i && !hold_i) |=> active_o);

endmodule

// File: rtl/rxwk_boost.sv
module rxwk_boost
  import rxwk_pkg::*;
#(
  parameter int unsigned LEN = DEF_BOOST_CYCLES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  output logic boost_o,
  output logic en_o
);

  localparam int unsigned CW   = cnt_w(LEN);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          boost_q, boost_d;
  logic          prev_q, prev_d;
  logic          en_q, en_d;

  always_comb begin
    cnt_d   = cnt_q;
    boost_d = boost_q;
    prev_d  = hold_i;
    en_d    = !hold_i;
    if (hold_i) begin
      boost_d = 1'b0;
      cnt_d   = '0;
    end else if (prev_q) begin
      boost_d = 1'b1;
      cnt_d   = LAST;
    end else if (boost_q) begin
      if (cnt_q == '0) boost_d = 1'b0;
      else             cnt_d   = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      boost_q <= 1'b0;
      prev_q  <= 1'b1;
      en_q    <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      boost_q <= boost_d;
      prev_q  <= prev_d;
      en_q    <= en_d;
    end
  end

  assign boost_o = boost_q;
  assign en_o    = en_q;

  // R7: leaving standby opens the window on the next edge
  a_r7_window_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && prev_q) |=> boost_o);

  // R7: the window stays open while the timer has cycles left
  a_r7_window_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (boost_o && cnt_q != '0 && !hold_i) |=> boost_o);

  // R8: standby closes the window and the sources together
  a_r8_shut_kills: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (!boost_o && !en_o));

  // R6: boost never runs without the sources enabled
  a_r6_boost_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    boost_o |-> en_o);

endmodule

// File: rtl/rxwk_ctrl.sv
module rxwk_ctrl
  import rxwk_pkg::*;
#(
  parameter int unsigned TICK_DIV     = DEF_TICK_DIV,
  parameter int unsigned QUAL_TICKS   = DEF_QUAL_TICKS,
  parameter int unsigned BOOST_CYCLES = DEF_BOOST_CYCLES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shut_req,
  input  logic carrier_raw,
  output logic wake_n,
  output logic agc_en,
  output logic agc_boost
);

  logic [1:0] sync_q;
  logic       shut_s;
  logic       carrier_s;
  logic       tick;
  logic       active;

  // bit 0 standby (resets to standby), bit 1 carrier (resets absent)
  rxwk_sync #(.WIDTH(2), .RST_VAL(2'b01)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({carrier_raw, shut_req}),
    .q_sync  (sync_q)
  );

  assign shut_s    = sync_q[0];
  assign carrier_s = sync_q[1];

  rxwk_prescale #(.DIV(TICK_DIV)) u_prescale (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (!shut_s),
    .tick_o (tick)
  );

  rxwk_qual #(.QUAL(QUAL_TICKS)) u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_i    (shut_s),
    .carrier_i (carrier_s),
    .tick_i    (tick),
    .active_o  (active)
  );

  rxwk_boost #(.LEN(BOOST_CYCLES)) u_boost (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_i  (shut_s),
    .boost_o (agc_boost),
    .en_o    (agc_en)
  );

  assign wake_n = ~active;

  // R5: standby at the synchronizer output forces the flag high next edge
  a_r5_standby_flag: assert property (@(posedge clk) disable iff (!rst_n)
    shut_s |=> (wake_n && !agc_boost));

  // R1: reset value check on the outputs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_outputs: assert (wake_n && !agc_en && !agc_boost);
    end
  end

endmodule

// File: tb/rxwk_ctrl_tb_top.sv
module rxwk_ctrl_tb_top;

  localparam int TB_DIV   = 8;
  localparam int TB_QUAL  = 16;
  localparam int TB_BOOST = 200;

  logic clk = 1'b0;
  logic rst_n;
  logic shut_req;
  logic carrier_raw;
  logic wake_n;
  logic agc_en;
  logic agc_boost;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rxwk_ctrl #(
    .TICK_DIV     (TB_DIV),
    .QUAL_TICKS   (TB_QUAL),
    .BOOST_CYCLES (TB_BOOST)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .shut_req    (shut_req),
    .carrier_raw (carrier_raw),
    .wake_n      (wake_n),
    .agc_en      (agc_en),
    .agc_boost   (agc_boost)
  );

  task automatic chk(input string req, input string sig, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, sig, act, exp, $time);
    end
  endtask

  // edge at which wake_n is expected to fall (R2/R3)
  function automatic int wake_edge(input int g);
    int k;
    k = (g + TB_DIV - 1) / TB_DIV;
    if (k < 1) k = 1;
    return (k + TB_QUAL - 1) * TB_DIV + 1;
  endfunction

  // one release from standby; gap_s < 0 means no carrier gap, shut_at < 0 means no re-shut
  task automatic run_release(input int gap_s, input int gap_w, input int shut_at, input string tag);
    int  w;
    int  last;
    bit  wake_exp;
    bit  boost_exp;
    bit  en_exp;
    bit  cut;
    shut_req    = 1'b1;
    carrier_raw = 1'b1;
    repeat (6) @(negedge clk);
    chk("R5", "wake_n in standby", wake_n, 1'b1);
    chk("R5", "agc_boost in standby", agc_boost, 1'b0);
    chk("R6", "agc_en in standby", agc_en, 1'b0);
    shut_req = 1'b0;
    w = wake_edge((gap_s >= 0) ? gap_s + gap_w + 1 : 0);
    last = ((w > TB_BOOST + 2) ? w : TB_BOOST + 2) + 3;
    for (int j = 0; j <= last; j++) begin
      if (gap_s >= 0 && j == gap_s)         carrier_raw = 1'b0;
      if (gap_s >= 0 && j == gap_s + gap_w) carrier_raw = 1'b1;
      if (shut_at >= 0 && j == shut_at)     shut_req = 1'b1;
      @(negedge clk);
      cut       = (shut_at >= 0) && (j >= shut_at + 2);
      wake_exp  = !((j >= w) && !cut && ((shut_at < 0) || (w <= shut_at + 1)));
      boost_exp = (j >= 2) && (j <= TB_BOOST + 1) && !cut;
      en_exp    = (j >= 2) && !cut;
      chk(tag, "wake_n", wake_n, wake_exp);                 // R2 R3 R9 R10
      chk((shut_at >= 0) ? "R8" : "R7", "agc_boost", agc_boost, boost_exp);
      chk("R6", "agc_en", agc_en, en_exp);
    end
    if (shut_at < 0) begin
      carrier_raw = 1'b0;                                    // sampled at F0
      @(negedge clk);
      @(negedge clk);
      chk("R4", "wake_n after F1", wake_n, 1'b0);
      @(negedge clk);
      chk("R4", "wake_n after F2", wake_n, 1'b1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    int gs, gw, sa;
    seed_v = $urandom(32'd715);
    rst_n       = 1'b0;
    shut_req    = 1'b1;
    carrier_raw = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "wake_n in reset", wake_n, 1'b1);
    chk("R1", "agc_en in reset", agc_en, 1'b0);
    chk("R1", "agc_boost in reset", agc_boost, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "wake_n after reset", wake_n, 1'b1);
    chk("R1", "agc_boost after reset", agc_boost, 1'b0);

    // R5: long carrier during standby never wakes
    for (int j = 0; j < 3 * TB_DIV * TB_QUAL; j++) begin
      @(negedge clk);
      if (j % 64 == 0) chk("R5", "wake_n long standby", wake_n, 1'b1);
    end

    // R2 and R10: steady carrier, wake falls inside the boost window
    run_release(-1, 0, -1, "R2");
    // R9: standby arrives in the cycle of the final tick
    run_release(-1, 0, wake_edge(0) - 2, "R9");
    // R8: standby mid window, then a fresh full window
    run_release(-1, 0, 50, "R8");
    run_release(-1, 0, -1, "R10");
    // R3: gap exactly at a tick boundary
    run_release(TB_DIV - 1, 1, -1, "R3");

    // random gaps and standby instants
    for (int t = 0; t < 12; t++) begin
      gs = $urandom_range(100, 3);
      gw = $urandom_range(6, 1);
      sa = (t % 3 == 2) ? $urandom_range(260, 3) : -1;
      run_release(gs, gw, sa, "R3");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule